// File: doc/BRIEF.md
# JTAG Debug Transport Front End with Self-Reset

This block is the JTAG-facing transport of an on-chip debug path. It runs the standard IEEE 1149.1 TAP state machine on TCK and holds a 5-bit instruction register. It also holds three data registers: a 32-bit identification code, a 32-bit transport control/status word, and a 1-bit bypass stage. The control/status word reports fixed configuration fields and a sticky debug-bus status. That status is built from the response and busy indications the debug bus returns to the transport.

Two write-only bits in the control/status word give software a way to recover the transport. The soft bit clears only the sticky bus status. The hard bit is latched into a dedicated request flop during Update-DR. On the next TCK rising edge it returns the whole transport to its reset state: the TAP goes to Test-Logic-Reset, the instruction register goes back to the identification code, and the bus status is cleared. The hard reset touches only the transport. No reset leaves the block toward the debug module, so a bus access that is already outstanding may still be unresolved afterwards.

Top module: `jtag_dbg_xport`

## Requirements
- R1: While `trst_ni` is low, the TAP is held in Test-Logic-Reset with instruction 0x01 selected and `tdo_oe_o` low. This also applies when `trst_ni` is pulled low asynchronously in the middle of a scan. After release, a data scan with no preceding instruction scan returns the identification code.
- R2: Five consecutive TCK rising edges with TMS high bring the TAP to Test-Logic-Reset from any state. That selects instruction 0x01 and clears the sticky bus status.
- R3: The instruction register is 5 bits wide, shifted LSB first. Capture-IR loads binary 00001, so every instruction scan shifts out 0x01. The new value takes effect in Update-IR.
- R4: Instruction 0x01 selects a 32-bit data register that captures the `IDCODE` parameter and shifts LSB first.
- R5: Instruction 0x11 selects a 32-bit control/status word. Its capture value holds the following fields; every other bit, including the soft-reset and hard-reset bits, reads 0:
  - [3:0] = 1
  - [9:4] = `ABITS`
  - [11:10] = sticky bus status
  - [14:12] = `IDLE_HINT`
- R6: Every instruction value other than 0x01 and 0x11 selects a 1-bit bypass stage. It captures 0, so the data shifted out is the shifted-in data delayed by one bit with a leading 0.
- R7: The sticky bus status reads 0 when clean. A failed response (`dbus_rsp_valid_i` and `dbus_rsp_fail_i`) sets it to 2, and `dbus_busy_i` sets it to 3. A failed response wins over busy. Once the status is non-zero it holds its value until it is cleared.
- R8: A 1 in bit 16 of the control/status word at Update-DR clears the sticky bus status. The instruction register and the TAP are left untouched, so instruction 0x11 stays selected.
- R9: A 1 in bit 17 of the control/status word at Update-DR is latched. On the following TCK rising edge, whatever TMS is, the TAP enters Test-Logic-Reset, the instruction register becomes 0x01 and the sticky bus status is cleared.
- R10: A bus failure or busy indication sampled on the same TCK edge as a soft-reset Update-DR is dropped, and the status reads 0 afterwards.
- R11: TDO changes on the falling edge of TCK. `tdo_oe_o` is high only while the TAP is in Shift-IR or Shift-DR, and `tdo_o` is 0 whenever `tdo_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | JTAG test clock |
| trst_ni | input | 1 | Asynchronous active-low test reset, released on TCK |
| tms_i | input | 1 | Test mode select |
| tdi_i | input | 1 | Test data in |
| tdo_o | output | 1 | Test data out, updated on the TCK falling edge |
| tdo_oe_o | output | 1 | Output enable for TDO, high in Shift-IR and Shift-DR |
| dbus_rsp_valid_i | input | 1 | Debug-bus response strobe |
| dbus_rsp_fail_i | input | 1 | Debug-bus response failed, qualified by the strobe |
| dbus_busy_i | input | 1 | Debug bus reports an access still in progress |

## Verification
The sticky bus status has a set path (a failed or busy bus indication) and a clear path (the soft-reset write). Both can act on the same TCK edge. The bench raises a failed response exactly in the Update-DR cycle of a soft-reset scan and expects a clean status on the next read. It then raises the same failure alone to show that the set path still works. The hard-reset request and an ordinary TMS move also meet on one edge. The bench holds TMS high in the cycle the latched request is applied, so a transport that ignored the request would walk into a DR scan. The bench judges this through `tdo_oe_o` two cycles later.

// File: rtl/jdx_pkg.sv
package jdx_pkg;

  localparam int unsigned IR_W     = 5;
  localparam int unsigned DR_W     = 32;
  localparam int unsigned SOFT_BIT = 16;
  localparam int unsigned HARD_BIT = 17;

  localparam logic [IR_W-1:0] IR_IDCODE  = 5'h01;
  localparam logic [IR_W-1:0] IR_XCSR    = 5'h11;
  localparam logic [IR_W-1:0] IR_CAPTURE = 5'b00001;

  localparam logic [1:0] ST_OK   = 2'd0;
  localparam logic [1:0] ST_FAIL = 2'd2;
  localparam logic [1:0] ST_BUSY = 2'd3;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {SEL_IDC, SEL_CSR, SEL_BYP} dr_sel_e;

endpackage

// File: rtl/jdx_rst_sync.sv
module jdx_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic q1, q2;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      q1 <= 1'b0;
      q2 <= 1'b0;
    end else begin
      q1 <= 1'b1;
      q2 <= q1;
    end
  end

  assign rst_no = q2;
endmodule

// File: rtl/jdx_tap_fsm.sv
module jdx_tap_fsm
  import jdx_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  input  logic       force_reset_i,
  output tap_state_e state_o
);
  tap_state_e state_q, state_nx, state_d;

  always_comb begin
    unique case (state_q)
      TS_RESET:  state_nx = tms_i ? TS_RESET  : TS_IDLE;
      TS_IDLE:   state_nx = tms_i ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: state_nx = tms_i ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: state_nx = tms_i ? TS_EX1_DR : TS_SHF_DR;
      TS_SHF_DR: state_nx = tms_i ? TS_EX1_DR : TS_SHF_DR;
      TS_EX1_DR: state_nx = tms_i ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: state_nx = tms_i ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: state_nx = tms_i ? TS_UPD_DR : TS_SHF_DR;
      TS_UPD_DR: state_nx = tms_i ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: state_nx = tms_i ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: state_nx = tms_i ? TS_EX1_IR : TS_SHF_IR;
      TS_SHF_IR: state_nx = tms_i ? TS_EX1_IR : TS_SHF_IR;
      TS_EX1_IR: state_nx = tms_i ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: state_nx = tms_i ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: state_nx = tms_i ? TS_UPD_IR : TS_SHF_IR;
      TS_UPD_IR: state_nx = tms_i ? TS_SEL_DR : TS_IDLE;
      default:   state_nx = TS_RESET;
    endcase
    state_d = force_reset_i ? TS_RESET : state_nx;
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= TS_RESET;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // Run of TMS-high edges, saturating, kept for the five-ones property.
  logic [2:0] ones_q;
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                 ones_q <= 3'd0;
    else if (!tms_i)             ones_q <= 3'd0;
    else if (ones_q != 3'd5)     ones_q <= ones_q + 3'd1;
  end

  // R2: fifth consecutive TMS-high edge lands in Test-Logic-Reset
  a_r2_five_ones_reset: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (tms_i && ones_q >= 3'd4) |=> state_q == TS_RESET);

  // R9: a latched hard-reset request wins over the TMS walk
  a_r9_force_tlr: assert property (@(posedge tck_i) disable iff (!rst_ni)
    force_reset_i |=> state_q == TS_RESET);
endmodule

// File: rtl/jdx_dtm_regs.sv
module jdx_dtm_regs
  import jdx_pkg::*;
#(
  parameter logic [DR_W-1:0] IDCODE    = 32'h4A7E_1C63,
  parameter int unsigned     ABITS     = 7,
  parameter int unsigned     IDLE_HINT = 5
) (
  input  logic       tck_i,
  input  logic       rst_ni,
  input  tap_state_e state_i,
  input  logic       tdi_i,
  input  logic       rsp_valid_i,
  input  logic       rsp_fail_i,
  input  logic       busy_i,
  output logic       hard_req_o,
  output logic       shift_bit_o
);
  localparam logic [5:0] ABITS_F = 6'(ABITS);
  localparam logic [2:0] IDLE_F  = 3'(IDLE_HINT);

  logic [IR_W-1:0] ir_q, ir_d, irs_q, irs_d;
  logic [DR_W-1:0] drs_q, drs_d, csr_cap;
  logic [1:0]      sticky_q, sticky_d;
  logic            hr_q, hr_d;
  logic            ir_en, irs_en, drs_en, st_en;
  logic            tlr, upd_csr, soft_hit, hard_hit, st_clr, fail_ev, busy_ev;
  dr_sel_e         sel;

  always_comb begin
    unique case (ir_q)
      IR_IDCODE: sel = SEL_IDC;
      IR_XCSR:   sel = SEL_CSR;
      default:   sel = SEL_BYP;
    endcase
  end

  assign csr_cap  = {17'd0, IDLE_F, sticky_q, ABITS_F, 4'd1};
  assign tlr      = (state_i == TS_RESET);
  assign upd_csr  = (state_i == TS_UPD_DR) && (sel == SEL_CSR);
  assign soft_hit = upd_csr && drs_q[SOFT_BIT];
  assign hard_hit = upd_csr && drs_q[HARD_BIT];
  assign fail_ev  = rsp_valid_i && rsp_fail_i;
  assign busy_ev  = busy_i;

  // Next-state logic with explicit enables
  always_comb begin
    ir_en  = hr_q || tlr || (state_i == TS_UPD_IR);
    ir_d   = (hr_q || tlr) ? IR_IDCODE : irs_q;

    irs_en = (state_i == TS_CAP_IR) || (state_i == TS_SHF_IR);
    irs_d  = (state_i == TS_CAP_IR) ? IR_CAPTURE : {tdi_i, irs_q[IR_W-1:1]};

    drs_en = (state_i == TS_CAP_DR) || (state_i == TS_SHF_DR);
    if (state_i == TS_CAP_DR) begin
      unique case (sel)
        SEL_IDC: drs_d = IDCODE;
        SEL_CSR: drs_d = csr_cap;
        default: drs_d = '0;
      endcase
    end else if (sel == SEL_BYP) begin
      drs_d = {{(DR_W-1){1'b0}}, tdi_i};
    end else begin
      drs_d = {tdi_i, drs_q[DR_W-1:1]};
    end

    hr_d = hard_hit && !hr_q && !tlr;

    st_clr   = hr_q || tlr || soft_hit;
    st_en    = st_clr || ((sticky_q == ST_OK) && (fail_ev || busy_ev));
    sticky_d = st_clr ? ST_OK : (fail_ev ? ST_FAIL : ST_BUSY);
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q     <= IR_IDCODE;
      irs_q    <= '0;
      drs_q    <= '0;
      hr_q     <= 1'b0;
      sticky_q <= ST_OK;
    end else begin
      if (ir_en)  ir_q     <= ir_d;
      if (irs_en) irs_q    <= irs_d;
      if (drs_en) drs_q    <= drs_d;
      if (st_en)  sticky_q <= sticky_d;
      hr_q <= hr_d;
    end
  end

  assign hard_req_o  = hr_q;
  assign shift_bit_o = (state_i == TS_SHF_IR) ? irs_q[0] : drs_q[0];

  // R9: request applies the transport reset on the next edge
  a_r9_hard_reset_state: assert property (@(posedge tck_i) disable iff (!rst_ni)
    hr_q |=> (ir_q == IR_IDCODE) && (sticky_q == ST_OK));

  // R9: the latched request lives for exactly one cycle
  a_r9_hard_req_pulse: assert property (@(posedge tck_i) disable iff (!rst_ni)
    hr_q |=> !hr_q);

  // R8: soft reset clears status but keeps the selected instruction
  a_r8_soft_keeps_ir: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (soft_hit && !hard_hit) |=> (ir_q == IR_XCSR) && (sticky_q == ST_OK));

  // R3: Capture-IR loads the fixed pattern
  a_r3_ir_capture: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == TS_CAP_IR) |=> irs_q == IR_CAPTURE);

  // R7: a non-zero status holds until a clear source appears
  a_r7_sticky_hold: assert property (@(posedge tck_i) disable iff (!rst_ni)
    ((sticky_q != ST_OK) && !hr_q && !tlr && !soft_hit) |=> sticky_q == $past(sticky_q));
endmodule

// File: rtl/jtag_dbg_xport.sv
module jtag_dbg_xport
  import jdx_pkg::*;
#(
  parameter logic [31:0] IDCODE    = 32'h4A7E_1C63,
  parameter int unsigned ABITS     = 7,
  parameter int unsigned IDLE_HINT = 5
) (
  input  logic tck_i,
  input  logic trst_ni,
  input  logic tms_i,
  input  logic tdi_i,
  output logic tdo_o,
  output logic tdo_oe_o,
  input  logic dbus_rsp_valid_i,
  input  logic dbus_rsp_fail_i,
  input  logic dbus_busy_i
);
  logic       rst_n;
  tap_state_e state;
  logic       hard_req, shift_bit, shifting;
  logic       tdo_q, oe_q;

  jdx_rst_sync u_rst (
    .clk_i   (tck_i),
    .arst_ni (trst_ni),
    .rst_no  (rst_n)
  );

  jdx_tap_fsm u_tap (
    .tck_i         (tck_i),
    .rst_ni        (rst_n),
    .tms_i         (tms_i),
    .force_reset_i (hard_req),
    .state_o       (state)
  );

  jdx_dtm_regs #(
    .IDCODE    (IDCODE),
    .ABITS     (ABITS),
    .IDLE_HINT (IDLE_HINT)
  ) u_regs (
    .tck_i       (tck_i),
    .rst_ni      (rst_n),
    .state_i     (state),
    .tdi_i       (tdi_i),
    .rsp_valid_i (dbus_rsp_valid_i),
    .rsp_fail_i  (dbus_rsp_fail_i),
    .busy_i      (dbus_busy_i),
    .hard_req_o  (hard_req),
    .shift_bit_o (shift_bit)
  );

  assign shifting = (state == TS_SHF_IR) || (state == TS_SHF_DR);

  // Output stage on the falling edge of TCK
  always_ff @(negedge tck_i or negedge rst_n) begin
    if (!rst_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      tdo_q <= shifting ? shift_bit : 1'b0;
      oe_q  <= shifting;
    end
  end

  assign tdo_o    = tdo_q;
  assign tdo_oe_o = oe_q;

  // R11: no data on TDO while the driver is off
  a_r11_tdo_quiet: assert property (@(negedge tck_i) disable iff (!rst_n)
    !oe_q |-> !tdo_q);
endmodule

// File: tb/jtag_dbg_xport_tb_top.sv
module jtag_dbg_xport_tb_top;
  localparam logic [31:0] IDC   = 32'h4A7E_1C63;
  localparam int unsigned ABITS = 7;
  localparam int unsigned IDLE  = 5;

  logic tck = 1'b0;
  always #5 tck = ~tck;

  logic trst_n, tms, tdi, rv, rf, bz;
  logic tdo, oe;
  int   checks = 0;
  int   fails  = 0;
  int   cyc    = 0;
  bit   done   = 0;

  jtag_dbg_xport #(.IDCODE(IDC), .ABITS(ABITS), .IDLE_HINT(IDLE)) dut_i (
    .tck_i(tck), .trst_ni(trst_n), .tms_i(tms), .tdi_i(tdi),
    .tdo_o(tdo), .tdo_oe_o(oe),
    .dbus_rsp_valid_i(rv), .dbus_rsp_fail_i(rf), .dbus_busy_i(bz)
  );

  function automatic logic [31:0] exp_csr(input logic [1:0] st);
    return {17'd0, 3'(IDLE), st, 6'(ABITS), 4'd1};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge tck) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      summary();
      $finish;
    end
  end

  // st = {rsp_valid, rsp_fail, busy}, held for one rising edge
  task automatic step(input logic m, input logic d, input logic [2:0] st,
                      output logic o, output logic e);
    @(negedge tck);
    #1;
    tms = m; tdi = d; {rv, rf, bz} = st;
    #1;
    o = tdo; e = oe;
  endtask

  task automatic mv(input logic m);
    logic o, e;
    step(m, 1'b0, 3'b000, o, e);
  endtask

  task automatic scan_ir(input logic [4:0] v, output logic [4:0] cap);
    logic o, e;
    mv(1); mv(1); mv(0); mv(0);
    for (int i = 0; i < 5; i++) begin
      step(i == 4, v[i], 3'b000, o, e);
      cap[i] = o;
    end
    mv(1); mv(0);
  endtask

  task automatic scan_dr(input int n, input logic [31:0] din, input logic [2:0] upd_st,
                         output logic [31:0] dout, output bit oe_ok);
    logic o, e;
    dout = '0;
    oe_ok = 1;
    mv(1); mv(0);
    step(1'b0, 1'b0, 3'b000, o, e);
    if (e) oe_ok = 0;
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], 3'b000, o, e);
      dout[i] = o;
      if (!e) oe_ok = 0;
    end
    step(1'b1, 1'b0, 3'b000, o, e);
    if (e || o) oe_ok = 0;
    step(1'b0, 1'b0, upd_st, o, e);
    if (e) oe_ok = 0;
  endtask

  initial begin
    logic [4:0]  cap;
    logic [31:0] dv;
    bit          ok;
    logic        o, e;

    trst_n = 0; tms = 1; tdi = 0; rv = 0; rf = 0; bz = 0;
    repeat (3) @(negedge tck);
    #2;
    chk("R1 oe low in reset", {31'd0, oe}, 32'd0);
    trst_n = 1;
    mv(1); mv(1); mv(1); mv(0);

    // R1 / R4: IDCODE selected out of reset
    scan_dr(32, 32'h0, 3'b000, dv, ok);
    chk("R1 idcode after reset", dv, IDC);

    // R3 / R5 / R11
    scan_ir(5'h11, cap);
    chk("R3 ir capture", {27'd0, cap}, 32'h1);
    scan_dr(32, 32'h0, 3'b000, dv, ok);
    chk("R5 csr capture", dv, exp_csr(2'd0));
    chk("R11 oe only in shift", {31'd0, ok}, 32'd1);

    // R6: sweep every bypass instruction
    for (int v = 0; v < 32; v++) begin
      if (v != 1 && v != 17) begin
        logic [7:0] p;
        p = 8'((v * 37 + 11) & 8'hFF);
        scan_ir(5'(v), cap);
        scan_dr(8, {24'd0, p}, 3'b000, dv, ok);
        chk("R6 bypass delay", dv, {24'd0, p[6:0], 1'b0});
      end
    end

    // R4: reselect IDCODE explicitly
    scan_ir(5'h01, cap);
    scan_dr(32, 32'hFFFF_FFFF, 3'b000, dv, ok);
    chk("R4 idcode", dv, IDC);

    // R7: failure sets 2 and holds against busy
    scan_ir(5'h11, cap);
    step(0, 0, 3'b110, o, e);
    mv(0);
    scan_dr(32, 32'h0, 3'b000, dv, ok);
    chk("R7 fail sets 2", dv, exp_csr(2'd2));
    step(0, 0, 3'b001, o, e);
    mv(0);
    scan_dr(32, 32'h0, 3'b000, dv, ok);
    chk("R7 sticky holds", dv, exp_csr(2'd2));

    // R8: soft reset clears status, IR stays on control/status
    scan_dr(32, 32'h0001_0000, 3'b000, dv, ok);
    scan_dr(32, 32'h0, 3'b000, dv, ok);
    chk("R8 soft clear, ir kept", dv, exp_csr(2'd0));
    step(0, 0, 3'b001, o, e);
    mv(0);
    scan_dr(32, 32'h0, 3'b000, dv, ok);
    chk("R7 busy sets 3", dv, exp_csr(2'd3));

    // R10: failure on the soft-reset update edge is dropped
    scan_dr(32, 32'h0001_0000, 3'b110, dv, ok);
    scan_dr(32, 32'h0, 3'b000, dv, ok);
    chk("R10 soft wins same edge", dv, exp_csr(2'd0));
    step(0, 0, 3'b110, o, e);
    mv(0);
    scan_dr(32, 32'h0, 3'b000, dv, ok);
    chk("R10 fail alone still sets", dv, exp_csr(2'd2));

    // R9: hard reset, TMS high on the applying edge
    scan_dr(32, 32'h0002_0000, 3'b000, dv, ok);
    mv(1); mv(0); mv(0);
    step(0, 0, 3'b000, o, e);
    chk("R9 tap forced to reset", {31'd0, e}, 32'd0);
    scan_dr(32, 32'h0, 3'b000, dv, ok);
    chk("R9 ir back to idcode", dv, IDC);
    scan_ir(5'h11, cap);
    scan_dr(32, 32'h0, 3'b000, dv, ok);
    chk("R9 status cleared", dv, exp_csr(2'd0));

    // R2: five TMS-high edges from several states
    for (int k = 0; k < 5; k++) begin
      scan_ir(5'h11, cap);
      step(0, 0, 3'b110, o, e);
      case (k)
        1: begin mv(1); mv(0); mv(0); end
        2: begin mv(1); mv(0); mv(1); mv(0); end
        3: begin mv(1); mv(1); mv(0); mv(0); end
        4: begin mv(1); mv(1); mv(0); mv(1); mv(0); end
        default: ;
      endcase
      repeat (5) mv(1);
      mv(0);
      scan_dr(32, 32'h0, 3'b000, dv, ok);
      chk("R2 five ones to reset", dv, IDC);
      scan_ir(5'h11, cap);
      scan_dr(32, 32'h0, 3'b000, dv, ok);
      chk("R2 status cleared", dv, exp_csr(2'd0));
    end

    // R1: asynchronous TRST in the middle of a data scan
    scan_ir(5'h11, cap);
    mv(1); mv(0); mv(0); mv(0); mv(0);
    @(negedge tck);
    #1;
    trst_n = 0;
    #1;
    chk("R1 async trst stops tdo", {31'd0, oe}, 32'd0);
    repeat (2) @(negedge tck);
    #1;
    trst_n = 1;
    mv(1); mv(1); mv(1); mv(0);
    scan_dr(32, 32'h0, 3'b000, dv, ok);
    chk("R1 idcode after trst", dv, IDC);

    done = 1;
    summary();
    $finish;
  end
endmodule